// File: doc/BRIEF.md
# Cluster Logical Destination Matcher

This block belongs to one interrupt-target agent. It holds the agent's 32-bit logical identifier and decides whether an incoming logical-mode interrupt destination addresses that agent. Software cannot write the identifier. Hardware builds it from the agent's 32-bit physical identifier when cluster addressing is switched on.

The logical identifier has two fields:
- The upper half, bits [31:16], is a cluster number.
- The lower half, bits [15:0], is a one-hot member bit.

A destination hits when two conditions hold. Its cluster half must equal the stored cluster number. Its member half must share at least one set bit with the stored member bit. A destination aimed at several agents of one cluster is the OR of their identifiers, so its member half may carry many set bits.

The block supports only cluster addressing. It has no flat logical mode and no format register. The number of implemented cluster bits and member bits are parameters. Bits that are not implemented always read as zero.

Top module: `clus_dest_match`

## Requirements
- R1: After reset, `ldr_rdata` is zero and `hit` is low.
- R2: The member field `ldr_rdata[15:0]` holds at most one set bit. That bit is at position `pid[3:0]` when the position is below `MBW`. When the position is `MBW` or above, the field is zero.
- R3: The cluster field `ldr_rdata[31:16]` equals `pid[4 +: CLW]` zero-extended to 16 bits. Physical bits beyond that range are dropped. Cluster bits at position `CLW` and above always read zero.
- R4: The identifier is captured at the first clock edge where `mode_en` is sampled high after being low. While `mode_en` stays high, changes on `pid` have no effect on `ldr_rdata` or on matching.
- R5: At the first edge where `mode_en` is sampled low, the identifier clears to zero. `hit` is never set from a cycle in which `mode_en` is low, or in the cycle in which the mode is first enabled.
- R6: A hit requires `dst[31:16]` to equal `ldr_rdata[31:16]` in all 16 bits, including the unimplemented ones.
- R7: A hit requires `dst[15:0] & ldr_rdata[15:0]` to be non-zero. A destination with several member bits hits if any one of them matches. A zero member mask never hits.
- R8: `hit` is registered. It reflects the `dst_vld`/`dst` sampled at the previous edge, and it is low whenever `dst_vld` was low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_en | input | 1 | Cluster-addressing mode enable |
| pid | input | 32 | Physical identifier of the agent |
| ldr_rdata | output | 32 | Read-only logical identifier |
| dst_vld | input | 1 | Destination presented this cycle |
| dst | input | 32 | Logical destination: cluster in [31:16], member mask in [15:0] |
| hit | output | 1 | Destination addressed this agent (one cycle later) |

## Verification
The bench uses a reduced configuration with 12 cluster bits and 12 member bits. It sweeps every low-nibble value of the physical identifier over several cluster numbers, and it applies each single-bit member mask as well as full, zero and multi-bit masks. Each target exposes one kind of bug:

- Member positions 12 to 15: a design that keeps an unimplemented member bit would report a one-hot value and hit where no hit is allowed.
- Destinations that set an unimplemented cluster bit: a design that compares only the implemented width would falsely match.
- Changing the physical identifier while the mode stays enabled: a design that loads on the level of the enable would change identity.
- Disabling and re-enabling the mode: a design that does not clear or reload the identifier would keep a stale one.

The bench also presents a matching destination with `dst_vld` low and checks that no hit appears. A design that ignores the valid bit would hit there.

// File: rtl/clus_dest_match.sv
module clus_dest_match #(
  parameter int CLW = 16,
  parameter int MBW = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_en,
  input  logic [31:0] pid,
  output logic [31:0] ldr_rdata,
  input  logic        dst_vld,
  input  logic [31:0] dst,
  output logic        hit
);
  localparam logic [31:0] CL_MASK = ((32'd1 << CLW) - 32'd1) << 16;
  localparam logic [31:0] MB_MASK = (32'd1 << MBW) - 32'd1;
  localparam logic [31:0] IMPL    = CL_MASK | MB_MASK;

  logic        mode_q;
  logic [31:0] ldr_q;
  logic [31:0] ldr_nxt;
  logic        clus_eq;
  logic        memb_ov;

  assign ldr_nxt   = (((pid >> 4) << 16) | (32'd1 << pid[3:0])) & IMPL;
  assign clus_eq   = dst[31:16] == ldr_q[31:16];
  assign memb_ov   = |(dst[15:0] & ldr_q[15:0]);
  assign ldr_rdata = ldr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      ldr_q  <= '0;
      hit    <= 1'b0;
    end else begin
      mode_q <= mode_en;
      if (mode_en && !mode_q)
        ldr_q <= ldr_nxt;
      else if (!mode_en)
        ldr_q <= '0;
      hit <= dst_vld && mode_en && mode_q && clus_eq && memb_ov;
    end
  end
endmodule

module clus_dest_match_chk #(
  parameter int CLW = 16,
  parameter int MBW = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        mode_en,
  input logic        mode_q,
  input logic [31:0] ldr_rdata,
  input logic        dst_vld,
  input logic [31:0] dst,
  input logic        hit
);
  localparam logic [31:0] IMPL = (((32'd1 << CLW) - 32'd1) << 16) | ((32'd1 << MBW) - 32'd1);

  // R2
  member_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ldr_rdata[15:0]));

  // R3
  unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ldr_rdata & ~IMPL) == 32'd0);

  // R4
  ldr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_q) && $past(mode_en)) |-> $stable(ldr_rdata));

  // R5
  off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!mode_en) |-> ldr_rdata == 32'd0);

  // R5
  off_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(mode_en));

  // R6
  clus_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(dst[31:16]) == $past(ldr_rdata[31:16]));

  // R7
  zero_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(dst[15:0]) != 16'd0);

  // R8
  hit_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(dst_vld));
endmodule

bind clus_dest_match clus_dest_match_chk #(.CLW(CLW), .MBW(MBW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .mode_q(mode_q),
  .ldr_rdata(ldr_rdata), .dst_vld(dst_vld), .dst(dst), .hit(hit)
);

// File: tb/sim_clus_dest_match.sv
module sim_clus_dest_match;
  localparam int CLK_P = 10;
  localparam int CLW = 12;
  localparam int MBW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_en = 1'b0;
  logic [31:0] pid = '0;
  logic [31:0] ldr_rdata;
  logic dst_vld = 1'b0;
  logic [31:0] dst = '0;
  logic hit;

  int total = 0;
  int bad = 0;

  always #(CLK_P/2) clk = ~clk;

  clus_dest_match #(.CLW(CLW), .MBW(MBW)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .pid(pid),
    .ldr_rdata(ldr_rdata), .dst_vld(dst_vld), .dst(dst), .hit(hit)
  );

  function automatic logic [31:0] exp_ldr(input logic [31:0] p);
    logic [31:0] c, m;
    c = (p >> 4) % (32'd1 << CLW);
    m = (32'd1 << p[3:0]) % (32'd1 << MBW);
    return (c << 16) | m;
  endfunction

  function automatic logic exp_hit(input logic [31:0] l, input logic [31:0] d);
    return (d[31:16] == l[31:16]) && ((d[15:0] & l[15:0]) != 16'd0);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic enable(input logic [31:0] p);
    @(negedge clk); mode_en = 1'b0; pid = p;
    @(negedge clk);
    mode_en = 1'b1;
    @(negedge clk);
  endtask

  task automatic probe(input string req, input logic [31:0] d, input logic v, input logic e);
    @(negedge clk); dst = d; dst_vld = v;
    @(negedge clk); dst_vld = 1'b0;
    chk(req, {31'd0, hit}, {31'd0, e});
  endtask

  initial begin
    logic [31:0] clist [4];
    logic [31:0] l, p;
    clist[0] = 32'h0; clist[1] = 32'h1; clist[2] = 32'hABC; clist[3] = 32'hFFF;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 rdata", ldr_rdata, 32'd0);
    chk("R1 hit", {31'd0, hit}, 32'd0);
    rst_n = 1'b1;
    // R5: disabled, no hit
    probe("R5 off", 32'h0000_0001, 1'b1, 1'b0);
    for (int ci = 0; ci < 4; ci++) begin
      for (int n = 0; n < 16; n++) begin
        p = 32'h5A5A_0000 | (clist[ci] << 4) | 32'(n);
        enable(p);
        l = exp_ldr(p);
        // R2 R3
        chk("R2/R3 ldr", ldr_rdata, l);
        for (int b = 0; b < 16; b++)
          probe("R7 single", (l & 32'hFFFF_0000) | (32'd1 << b), 1'b1,
                exp_hit(l, (l & 32'hFFFF_0000) | (32'd1 << b)));
        probe("R7 full", l | 32'hFFFF, 1'b1, exp_hit(l, l | 32'hFFFF));
        probe("R7 multi", l | 32'h0505, 1'b1, exp_hit(l, l | 32'h0505));
        probe("R7 zero", l & 32'hFFFF_0000, 1'b1, 1'b0);
        probe("R6 lsb", (l ^ 32'h0001_0000) | 32'hFFFF, 1'b1, 1'b0);
        probe("R6 unimpl", l | 32'h1000_FFFF, 1'b1, 1'b0);
        probe("R8 novld", l | 32'hFFFF, 1'b0, 1'b0);
      end
    end
    // R4: pid change while enabled
    p = 32'h0000_0123;
    enable(p);
    l = exp_ldr(p);
    @(negedge clk); pid = 32'h0000_0457;
    repeat (3) @(negedge clk);
    chk("R4 hold", ldr_rdata, l);
    probe("R4 old hit", l, 1'b1, 1'b1);
    probe("R4 new miss", 32'h0045_0080, 1'b1, 1'b0);
    // R5: disable clears
    @(negedge clk); mode_en = 1'b0;
    @(negedge clk);
    chk("R5 clear", ldr_rdata, 32'd0);
    probe("R5 off hit", l, 1'b1, 1'b0);
    // R5: no hit in enable cycle
    @(negedge clk); mode_en = 1'b1; dst = exp_ldr(32'h0000_0457); dst_vld = 1'b1;
    @(negedge clk); dst_vld = 1'b0;
    chk("R5 en cycle", {31'd0, hit}, 32'd0);
    chk("R4 reload", ldr_rdata, exp_ldr(32'h0000_0457));
    probe("R8 after reload", exp_ldr(32'h0000_0457), 1'b1, 1'b1);
    @(negedge clk);
    chk("R8 drop", {31'd0, hit}, 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule